// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one burst request into the run of column addresses that a synchronous DRAM burst visits. A request gives a starting column, a length code and an ordering choice. The block then presents one column address per clock until the burst finishes, until it is cut short, or until the next request replaces it. A memory controller uses it next to its command sequencer. Issuing commands, moving data and aligning to read latency are left to the sequencer.

Fixed-length bursts of 2, 4 or 8 stay inside an aligned block of columns. The bits above the block keep their starting value. The low bits follow one of two orders. Sequential order counts upward and wraps inside the block. Interleaved order XORs the starting offset with the beat number. A full-page burst counts upward through the whole row and wraps at its end. It stops only on a terminate pulse.

The output is a plain stream that has a valid flag and no ready input. The memory interface takes one address on every clock, so there is no back-pressure: a consumer has to accept each address in the cycle it is valid. The request pulses are single-cycle controls and are not handshaked.

Top module: `bca_col_gen`

## Requirements
- R1: After a clock edge that samples `start` high, `col_valid` is high in the following cycle and `col_out` equals the sampled `start_col`.
- R2: The `len_code` encodings are: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives full page. Any other code gives 1 beat. `col_last` is high only on the final beat of a fixed-length burst, and `col_valid` falls in the cycle after that beat when no new start arrives.
- R3: In a 2-, 4- or 8-beat burst, the column bits above the low 1, 2 or 3 bits keep their starting value on every beat.
- R4: With `interleave` = 0, beat i carries low bits equal to (start offset + i) modulo the length. For example, length 8 from 5 gives 5,6,7,0,1,2,3,4, and length 4 from 3 gives 3,0,1,2.
- R5: With `interleave` = 1, beat i carries low bits equal to the start offset XOR i. For example, length 8 from 5 gives 5,4,7,6,1,0,3,2, and length 4 from 3 gives 3,2,1,0.
- R6: A full-page burst outputs start, start+1, and so on, modulo 2^COL_W. It never raises `col_last`, and it uses sequential order even when `interleave` = 1.
- R7: A `stop` pulse without `start` makes `col_valid` low in the next cycle. When `start` and `stop` are high together, `start` wins.
- R8: A `start` on the last beat begins the next burst in the very next cycle with no idle gap. A `start` during any other beat restarts from the new column.
- R9: Changes to `start_col`, `len_code` and `interleave` while `start` is low do not alter a burst already running.
- R10: During reset and in the first cycle after it, `col_valid` and `col_last` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a burst |
| stop | input | 1 | One-cycle pulse that ends the running burst |
| start_col | input | COL_W | First column of the burst |
| len_code | input | 3 | Burst length code (see R2) |
| interleave | input | 1 | 0 selects sequential order, 1 selects interleaved order |
| col_out | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | `col_out` carries a beat |
| col_last | output | 1 | Final beat of a fixed-length burst |

## Verification
All outputs come from registers, so beat 0 appears one cycle after the edge that samples `start`, and beat i appears i cycles after that. A `stop` or the end of a burst clears `col_valid` one cycle after the edge that samples it. The bench drives inputs on falling edges and compares every beat on the next falling edge, so each check lands half a period after the edge where the result changes. The expected address for every beat is computed from the starting offset, the block size and the order, using modulo arithmetic that is independent of the mask logic in the design.

// File: rtl/bca_pkg.sv
package bca_pkg;
  localparam int LEN_CODE_W = 3;
  localparam logic [LEN_CODE_W-1:0] LC_ONE  = 3'b000;
  localparam logic [LEN_CODE_W-1:0] LC_TWO  = 3'b001;
  localparam logic [LEN_CODE_W-1:0] LC_FOUR = 3'b010;
  localparam logic [LEN_CODE_W-1:0] LC_EIGHT = 3'b011;
  localparam logic [LEN_CODE_W-1:0] LC_PAGE = 3'b111;

  // Width of the in-block offset for a fixed length code
  function automatic int unsigned offset_bits(input logic [LEN_CODE_W-1:0] code);
    case (code)
      LC_TWO:   return 1;
      LC_FOUR:  return 2;
      LC_EIGHT: return 3;
      default:  return 0;
    endcase
  endfunction
endpackage

// File: rtl/bca_len_decode.sv
module bca_len_decode
  import bca_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  interleave,
  output logic [COL_W-1:0]      blk_mask,
  output logic                  full_page,
  output logic                  seq_order
);
  localparam int MAX_OFF = (COL_W < 3) ? COL_W : 3;

  logic [COL_W-1:0] fixed_mask;

  // One mask bit per offset position, up to the eight-beat block
  for (genvar b = 0; b < COL_W; b++) begin : g_mask
    if (b < MAX_OFF) begin : g_low
      assign fixed_mask[b] = (offset_bits(len_code) > b);
    end else begin : g_high
      assign fixed_mask[b] = 1'b0;
    end
  end

  always_comb begin
    full_page = (len_code == LC_PAGE);
    blk_mask  = full_page ? {COL_W{1'b1}} : fixed_mask;
    seq_order = full_page | ~interleave;
  end
endmodule

// File: rtl/bca_beat_ctrl.sv
module bca_beat_ctrl #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] mask_in,
  input  logic             full_in,
  input  logic             seq_in,
  output logic             active,
  output logic [COL_W-1:0] base_q,
  output logic [COL_W-1:0] beat_q,
  output logic [COL_W-1:0] mask_q,
  output logic             full_q,
  output logic             seq_q,
  output logic             at_end
);
  // A fixed burst ends when the beat count reaches the in-block mask
  assign at_end = active & ~full_q & (beat_q == mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      mask_q <= '0;
      full_q <= 1'b0;
      seq_q  <= 1'b1;
    end else if (start) begin
      active <= 1'b1;
      base_q <= start_col;
      beat_q <= '0;
      mask_q <= mask_in;
      full_q <= full_in;
      seq_q  <= seq_in;
    end else if (stop || at_end) begin
      active <= 1'b0;
    end else if (active) begin
      beat_q <= beat_q + 1'b1;
    end
  end
endmodule

// File: rtl/bca_addr_mix.sv
module bca_addr_mix #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             seq,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] flip;

  assign sum  = base + beat;
  assign flip = base ^ beat;

  // Bits inside the block follow the order, bits above it keep the base
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col[b] = mask[b] ? (seq ? sum[b] : flip[b]) : base[b];
  end
endmodule

// File: rtl/bca_col_gen.sv
module bca_col_gen
  import bca_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  stop,
  input  logic [COL_W-1:0]      start_col,
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  interleave,
  output logic [COL_W-1:0]      col_out,
  output logic                  col_valid,
  output logic                  col_last
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic             dec_seq;
  logic             run_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] blk_mask;
  logic             fp_q;
  logic             seq_q;
  logic             end_beat;

  bca_len_decode #(.COL_W(COL_W)) u_dec (
    .len_code  (len_code),
    .interleave(interleave),
    .blk_mask  (dec_mask),
    .full_page (dec_full),
    .seq_order (dec_seq)
  );

  bca_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .stop     (stop),
    .start_col(start_col),
    .mask_in  (dec_mask),
    .full_in  (dec_full),
    .seq_in   (dec_seq),
    .active   (run_q),
    .base_q   (base_q),
    .beat_q   (beat_q),
    .mask_q   (blk_mask),
    .full_q   (fp_q),
    .seq_q    (seq_q),
    .at_end   (end_beat)
  );

  bca_addr_mix #(.COL_W(COL_W)) u_mix (
    .base(base_q),
    .beat(beat_q),
    .mask(blk_mask),
    .seq (seq_q),
    .col (col_out)
  );

  assign col_valid = run_q;
  assign col_last  = end_beat;
endmodule

// File: rtl/bca_col_gen_chk.sv
module bca_col_gen_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             stop,
  input logic [COL_W-1:0] start_col,
  input logic [COL_W-1:0] col_out,
  input logic             col_valid,
  input logic             col_last,
  input logic [COL_W-1:0] blk_mask,
  input logic             fp_q
);
  // R1: first beat carries the sampled start column
  a_r1_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (col_valid && col_out == $past(start_col)));

  // R7: terminate without start empties the output
  a_r7_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !col_valid);

  // R2: last flag only on a valid beat of a fixed burst
  a_r2_last_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> (col_valid && !fp_q));

  // R2: nothing follows the final beat without a new start
  a_r2_end_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (col_last && !start && !stop) |=> !col_valid);

  // R3: bits above the block hold across consecutive beats
  a_r3_block_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_last && !start && !stop) |=>
      (col_valid && ((col_out & ~blk_mask) == ($past(col_out) & ~$past(blk_mask)))));
endmodule

bind bca_col_gen bca_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .stop     (stop),
  .start_col(start_col),
  .col_out  (col_out),
  .col_valid(col_valid),
  .col_last (col_last),
  .blk_mask (blk_mask),
  .fp_q     (fp_q)
);

// File: tb/tb_bca_col_gen.sv
module tb_bca_col_gen;
  localparam int COL_W = 9;
  localparam int COLS  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             stop = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0]       len_code = '0;
  logic             interleave = 1'b0;
  logic [COL_W-1:0] col_out;
  logic             col_valid;
  logic             col_last;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bca_col_gen #(.COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .start_col(start_col), .len_code(len_code), .interleave(interleave),
    .col_out(col_out), .col_valid(col_valid), .col_last(col_last)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int len_of(input logic [2:0] code);
    case (code)
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(input int base, input logic [2:0] code,
                                 input bit inter, input int i);
    int n, off, blk;
    if (code == 3'b111) return (base + i) % COLS;
    n = len_of(code);
    off = base % n;
    blk = base - off;
    if (inter) return blk + (off ^ i);
    return blk + ((off + i) % n);
  endfunction

  task automatic pulse_start(input int col, input logic [2:0] code, input bit inter);
    start_col = col[COL_W-1:0]; len_code = code; interleave = inter; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Full fixed-length burst, every beat and the idle cycle after it
  task automatic fixed_burst(input int col, input logic [2:0] code, input bit inter,
                             input string tag);
    int n = len_of(code);
    pulse_start(col, code, inter);
    for (int i = 0; i < n; i++) begin
      check(col_valid == 1'b1, {tag, " valid"}, int'(col_valid), 1);
      check(int'(col_out) == exp_col(col, code, inter, i), {tag, " col"},
            int'(col_out), exp_col(col, code, inter, i));
      check(col_last == (i == n - 1), {"R2 last ", tag}, int'(col_last), int'(i == n - 1));
      @(negedge clk);
    end
    check(col_valid == 1'b0, {"R2 end ", tag}, int'(col_valid), 0);
  endtask

  task automatic t_reset;
    check(col_valid == 1'b0, "R10 valid in reset", int'(col_valid), 0);
    check(col_last == 1'b0, "R10 last in reset", int'(col_last), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(col_valid == 1'b0, "R10 valid after reset", int'(col_valid), 0);
  endtask

  task automatic t_orders;
    fixed_burst(5, 3'b011, 1'b0, "R4 seq8@5");
    fixed_burst(5, 3'b011, 1'b1, "R5 int8@5");
    fixed_burst(3, 3'b010, 1'b0, "R4 seq4@3");
    fixed_burst(3, 3'b010, 1'b1, "R5 int4@3");
    fixed_burst(9'h1A5, 3'b011, 1'b0, "R3 seq8 high bits");
    fixed_burst(9'h0F7, 3'b010, 1'b1, "R3 int4 high bits");
    fixed_burst(9'h033, 3'b001, 1'b0, "R4 seq2@odd");
    fixed_burst(9'h033, 3'b001, 1'b1, "R5 int2@odd");
    fixed_burst(9'h12C, 3'b000, 1'b0, "R2 len1");
    fixed_burst(9'h12E, 3'b100, 1'b1, "R2 reserved code");
  endtask

  task automatic t_full_page;
    pulse_start(COLS - 2, 3'b111, 1'b1);
    for (int i = 0; i < 5; i++) begin
      check(col_valid == 1'b1, "R6 full valid", int'(col_valid), 1);
      check(int'(col_out) == (COLS - 2 + i) % COLS, "R6 full wrap/seq",
            int'(col_out), (COLS - 2 + i) % COLS);
      check(col_last == 1'b0, "R6 full no last", int'(col_last), 0);
      if (i == 4) stop = 1'b1;
      @(negedge clk);
    end
    stop = 1'b0;
    check(col_valid == 1'b0, "R7 stop ends full page", int'(col_valid), 0);
  endtask

  task automatic t_stop_mid;
    pulse_start(16, 3'b011, 1'b0);
    @(negedge clk);
    check(int'(col_out) == 17, "R7 before stop", int'(col_out), 17);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check(col_valid == 1'b0, "R7 stop mid burst", int'(col_valid), 0);
    // start and stop together: start wins
    start_col = 9'd40; len_code = 3'b010; interleave = 1'b0; start = 1'b1; stop = 1'b1;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    check(col_valid == 1'b1, "R7 start beats stop", int'(col_valid), 1);
    check(int'(col_out) == 40, "R7 start beats stop col", int'(col_out), 40);
    repeat (4) @(negedge clk);
    check(col_valid == 1'b0, "R7 idle after", int'(col_valid), 0);
  endtask

  task automatic t_back_to_back;
    pulse_start(0, 3'b001, 1'b0);
    @(negedge clk);
    check(col_last == 1'b1, "R8 first burst last", int'(col_last), 1);
    start_col = 9'd9; len_code = 3'b010; interleave = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(col_valid == 1'b1, "R8 no gap valid", int'(col_valid), 1);
    check(int'(col_out) == 9, "R8 no gap col", int'(col_out), 9);
    @(negedge clk);
    check(int'(col_out) == 8, "R8 second beat", int'(col_out), 8);
    // restart mid burst
    start_col = 9'd100; len_code = 3'b000; interleave = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(int'(col_out) == 100, "R8 restart col", int'(col_out), 100);
    check(col_last == 1'b1, "R8 restart last", int'(col_last), 1);
    @(negedge clk);
    check(col_valid == 1'b0, "R8 restart end", int'(col_valid), 0);
  endtask

  task automatic t_ignore_inputs;
    pulse_start(5, 3'b011, 1'b0);
    start_col = 9'h1FF; len_code = 3'b111; interleave = 1'b1;
    for (int i = 0; i < 8; i++) begin
      check(int'(col_out) == exp_col(5, 3'b011, 1'b0, i), "R9 inputs ignored",
            int'(col_out), exp_col(5, 3'b011, 1'b0, i));
      @(negedge clk);
    end
    check(col_valid == 1'b0, "R9 length kept", int'(col_valid), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_orders();
    t_full_page();
    t_stop_mid();
    t_back_to_back();
    t_ignore_inputs();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule